// File: doc/BRIEF.md
# Masked Program Image Checksum Engine

This block folds a stream of 14-bit program words into a 16-bit image checksum. An external fetcher presents one word per cycle with its address. A start pulse clears the running sum, and the final word is flagged. The block decides per word whether that address counts. It bases the decision on the code-protection field held in the configuration word and on the device size, which is 2K, 4K or 8K words.

When the flagged final word is accepted, the block forms the result. It adds the configuration word with bit 10 and bits above 13 cleared, and, when protection is in force, one 16-bit value built from the low nibbles of the four identification words. Only the low 16 bits of the total are kept. The result appears one cycle later together with a one-cycle done pulse, and it is held until the next completion.

Top module: `cks_engine`

## Requirements
- R1: After reset, `done` is 0 and `sum_out` is 0x0000.
- R2: `done` is 1 exactly in the cycle after a word with `word_last` = 1 is accepted, and 0 otherwise; `sum_out` changes only when `done` rises.
- R3: Carries above bit 15 are dropped at every addition; the result is the total modulo 65536 (a blank 4K image with configuration 0x3FFF gives 0x2BFF, and a blank 2K image gives 0x33FF).
- R4: The configuration word is ANDed with 0x3BFF before it is added, so bit 10 never contributes.
- R5: The protection field is the pair `cfg_word[13:12]`, which must equal `cfg_word[5:4]`. With field value 11 every word at an address below MEM_WORDS is summed, words at higher addresses are skipped, and no ID term is added.
- R6: With field 10 (both pairs), only addresses below MEM_WORDS-256 are summed and the ID term is added.
- R7: With field 01 (both pairs), only addresses below MEM_WORDS/2 are summed and the ID term is added.
- R8: With field 00 (both pairs), no program word is summed and the ID term is added.
- R9: When `cfg_word[13:12]` differs from `cfg_word[5:4]`, the block behaves as for field 11.
- R10: The ID term is {id0[3:0], id1[3:0], id2[3:0], id3[3:0]}, with idN at `id_words[14*N+13:14*N]`; the upper ten bits of each ID word are ignored (IDs 1,2,3,4 give 0x1234).
- R11: `start` clears the running sum; a word presented in the same cycle as `start` is not accepted, and `done` is 0 in the cycle after `start`.
- R12: Cycles with `word_valid` = 0 add nothing, whatever `word_data` and `word_addr` hold.
- R13: With MEM_WORDS = 2048, fields 10 and 01 behave as field 11; field 00 still excludes all program words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Clears the running sum |
| word_valid | input | 1 | A word is presented this cycle |
| word_last | input | 1 | The presented word is the final one |
| word_addr | input | 14 | Address of the presented word |
| word_data | input | 14 | Program word value |
| cfg_word | input | 14 | Configuration word, stable during a run |
| id_words | input | 56 | Four ID words, id0 in the lowest 14 bits |
| done | output | 1 | One-cycle completion pulse |
| sum_out | output | 16 | Checksum, held until the next completion |

## Verification
The assertions check on every cycle that the completion pulse follows an accepted final word, that the result moves only together with that pulse, that a start is never followed by a completion, and that the per-word inclusion decision never takes an idle cycle, an address at or above the memory size, or any word under full protection. The arithmetic can only be shown by the bench's scenarios: carry loss, masking of the configuration word, the ID nibble packing, the partial-range limits for each protection field, the mismatched-pair fallback and the 2K-device variant. Each scenario feeds an address-dependent image and compares the result with a sum built from the requirements.

// File: rtl/cks_pkg.sv
package cks_pkg;
  localparam int WORD_W  = 14;
  localparam int ADDR_W  = 14;
  localparam int SUM_W   = 16;
  localparam int NUM_IDS = 4;
  localparam int NIB_W   = 4;
  localparam int TAIL_WORDS = 256;
  localparam int PART_MIN_WORDS = 4096;
  localparam logic [WORD_W-1:0] CFG_MASK = 14'h3BFF;
  localparam int PROT_HI_LSB = 12;
  localparam int PROT_LO_LSB = 4;

  typedef enum logic [1:0] {
    PROT_ALL  = 2'b00,
    PROT_HALF = 2'b01,
    PROT_TAIL = 2'b10,
    PROT_NONE = 2'b11
  } prot_e;
endpackage

// File: rtl/cks_range_sel.sv
module cks_range_sel
  import cks_pkg::*;
#(
  parameter int MEM_WORDS = 4096
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] cfg,
  output logic              in_range,
  output logic              id_en
);
  localparam int LIM_W = ADDR_W + 1;
  localparam logic [LIM_W-1:0] LIM_FULL = LIM_W'(MEM_WORDS);
  localparam logic [LIM_W-1:0] LIM_HALF = LIM_W'(MEM_WORDS / 2);
  localparam logic [LIM_W-1:0] LIM_TAIL = LIM_W'(MEM_WORDS - TAIL_WORDS);

  logic [1:0]       hi_pair;
  logic [1:0]       lo_pair;
  prot_e            raw_mode;
  prot_e            eff_mode;
  logic [LIM_W-1:0] limit;

  assign hi_pair = cfg[PROT_HI_LSB +: 2];
  assign lo_pair = cfg[PROT_LO_LSB +: 2];

  always_comb begin
    if (hi_pair == lo_pair) raw_mode = prot_e'(hi_pair);
    else                    raw_mode = PROT_NONE;
  end

  generate
    if (MEM_WORDS >= PART_MIN_WORDS) begin : g_partial
      assign eff_mode = raw_mode;
    end else begin : g_whole_only
      assign eff_mode = (raw_mode == PROT_ALL) ? PROT_ALL : PROT_NONE;
    end
  endgenerate

  always_comb begin
    unique case (eff_mode)
      PROT_ALL:  limit = '0;
      PROT_HALF: limit = LIM_HALF;
      PROT_TAIL: limit = LIM_TAIL;
      default:   limit = LIM_FULL;
    endcase
  end

  assign in_range = ({1'b0, addr} < limit);
  assign id_en    = (eff_mode != PROT_NONE);
endmodule

// File: rtl/cks_id_pack.sv
module cks_id_pack
  import cks_pkg::*;
(
  input  logic [NUM_IDS*WORD_W-1:0] id_words,
  output logic [NUM_IDS*NIB_W-1:0]  packed_id
);
  generate
    for (genvar i = 0; i < NUM_IDS; i++) begin : g_nib
      assign packed_id[(NUM_IDS-1-i)*NIB_W +: NIB_W] = id_words[i*WORD_W +: NIB_W];
    end
  endgenerate
endmodule

// File: rtl/cks_accum.sv
module cks_accum
  import cks_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              add_en,
  input  logic [WORD_W-1:0] add_val,
  output logic [SUM_W-1:0]  acc_next
);
  logic [SUM_W-1:0] acc_q;
  logic [SUM_W-1:0] acc_d;
  logic             acc_ce;

  always_comb begin
    acc_next = acc_q + SUM_W'(add_val);
    acc_ce   = clr | add_en;
    acc_d    = clr ? '0 : acc_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_ce) acc_q <= acc_d;
  end
endmodule

// File: rtl/cks_engine.sv
module cks_engine
  import cks_pkg::*;
#(
  parameter int MEM_WORDS = 4096
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic                      word_valid,
  input  logic                      word_last,
  input  logic [ADDR_W-1:0]         word_addr,
  input  logic [WORD_W-1:0]         word_data,
  input  logic [WORD_W-1:0]         cfg_word,
  input  logic [NUM_IDS*WORD_W-1:0] id_words,
  output logic                      done,
  output logic [SUM_W-1:0]          sum_out
);
  logic             in_range;
  logic             id_en;
  logic             word_take;
  logic             word_hit;
  logic             finish;
  logic [SUM_W-1:0] acc_next;
  logic [SUM_W-1:0] packed_id;
  logic [SUM_W-1:0] result_d;
  logic [SUM_W-1:0] result_q;
  logic             done_d;
  logic             done_q;

  cks_range_sel #(.MEM_WORDS(MEM_WORDS)) u_range (
    .addr     (word_addr),
    .cfg      (cfg_word),
    .in_range (in_range),
    .id_en    (id_en)
  );

  cks_id_pack u_idpack (
    .id_words  (id_words),
    .packed_id (packed_id)
  );

  assign word_take = word_valid & ~start;
  assign word_hit  = word_take & in_range;
  assign finish    = word_take & word_last;

  cks_accum u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (start),
    .add_en   (word_hit),
    .add_val  (word_hit ? word_data : '0),
    .acc_next (acc_next)
  );

  always_comb begin
    result_d = acc_next
             + SUM_W'(cfg_word & CFG_MASK)
             + (id_en ? packed_id : '0);
    done_d   = finish;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= done_d;
      if (finish) result_q <= result_d;
    end
  end

  assign done    = done_q;
  assign sum_out = result_q;
endmodule

// File: rtl/cks_engine_chk.sv
module cks_engine_chk
  import cks_pkg::*;
#(
  parameter int MEM_WORDS = 4096
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              word_valid,
  input logic              word_last,
  input logic [ADDR_W-1:0] word_addr,
  input logic [WORD_W-1:0] cfg_word,
  input logic              word_hit,
  input logic              done,
  input logic [SUM_W-1:0]  sum_out
);
  assert_done_follows_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(word_valid && word_last && !start))
    else $error("done without accepted final word");

  assert_sum_moves_with_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sum_out) |-> done)
    else $error("sum_out changed outside completion");

  assert_start_blocks_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done)
    else $error("done after start");

  assert_idle_adds_nothing_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid |-> !word_hit)
    else $error("idle cycle counted");

  assert_hit_below_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
    word_hit |-> (32'(word_addr) < MEM_WORDS))
    else $error("address beyond memory counted");

  assert_full_prot_no_words_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_word[PROT_HI_LSB +: 2] == 2'b00 && cfg_word[PROT_LO_LSB +: 2] == 2'b00) |-> !word_hit)
    else $error("word counted under full protection");
endmodule

bind cks_engine cks_engine_chk #(.MEM_WORDS(MEM_WORDS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .word_valid (word_valid),
  .word_last  (word_last),
  .word_addr  (word_addr),
  .cfg_word   (cfg_word),
  .word_hit   (word_hit),
  .done       (done),
  .sum_out    (sum_out)
);

// File: tb/test_cks_engine.sv
module test_cks_engine;
  logic        clk;
  logic        rst_n;
  logic        start;
  logic        word_valid;
  logic        word_last;
  logic [13:0] word_addr;
  logic [13:0] word_data;
  logic [13:0] cfg_word;
  logic [55:0] id_words;
  logic        done4, done2;
  logic [15:0] sum4, sum2;

  int tests_run = 0;
  int tests_failed = 0;
  bit finished = 0;

  cks_engine #(.MEM_WORDS(4096)) i_cks_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .word_valid(word_valid),
    .word_last(word_last), .word_addr(word_addr), .word_data(word_data),
    .cfg_word(cfg_word), .id_words(id_words), .done(done4), .sum_out(sum4));

  cks_engine #(.MEM_WORDS(2048)) i_cks_engine_2k (
    .clk(clk), .rst_n(rst_n), .start(start), .word_valid(word_valid),
    .word_last(word_last), .word_addr(word_addr), .word_data(word_data),
    .cfg_word(cfg_word), .id_words(id_words), .done(done2), .sum_out(sum2));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests_run++;
    if (!ok) begin
      tests_failed++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Requirement model: does address count, and is the ID term added
  function automatic bit counts(input int addr, input logic [13:0] cfg, input int words);
    int mode;
    int lim;
    mode = (cfg[13:12] == cfg[5:4]) ? int'(cfg[13:12]) : 3;
    if (words < 4096 && (mode == 1 || mode == 2)) mode = 3;
    case (mode)
      0: lim = 0;
      1: lim = words / 2;
      2: lim = words - 256;
      default: lim = words;
    endcase
    return addr < lim;
  endfunction

  function automatic bit ids_on(input logic [13:0] cfg, input int words);
    int mode;
    mode = (cfg[13:12] == cfg[5:4]) ? int'(cfg[13:12]) : 3;
    if (words < 4096 && (mode == 1 || mode == 2)) mode = 3;
    return mode != 3;
  endfunction

  function automatic logic [15:0] pack_ids(input logic [55:0] ids);
    return {ids[3:0], ids[17:14], ids[31:28], ids[45:42]};
  endfunction

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    word_valid = 1'b1;
    word_last = 1'b1;
    word_addr = 14'd0;
    word_data = 14'h3FFF;
    @(negedge clk);
    start = 1'b0;
    word_valid = 1'b0;
    word_last = 1'b0;
    check(done4 == 1'b0, "R11 done after start", done4, 0);
  endtask

  // Sends words 0..nwords-1, with pattern data; checks both instances
  task automatic run_image(input logic [13:0] cfg, input logic [55:0] ids,
                           input int nwords, input int seed, input bit blank,
                           input bit gaps, input string req);
    logic [15:0] e4, e2;
    logic [13:0] d;
    cfg_word = cfg;
    id_words = ids;
    e4 = 16'h0;
    e2 = 16'h0;
    pulse_start();
    for (int a = 0; a < nwords; a++) begin
      d = blank ? 14'h3FFF : 14'((a * 37 + seed) ^ (a >> 3));
      if (gaps && (a % 3 == 1)) begin
        @(negedge clk);
        word_valid = 1'b0;
        word_last = 1'b1;
        word_addr = 14'(a);
        word_data = 14'h3FFF;
      end
      @(negedge clk);
      word_valid = 1'b1;
      word_last = (a == nwords - 1);
      word_addr = 14'(a);
      word_data = d;
      if (counts(a, cfg, 4096)) e4 = e4 + 16'(d);
      if (counts(a, cfg, 2048)) e2 = e2 + 16'(d);
      if (a != nwords - 1) begin
        // done stays low mid-stream
        if (a == 2) check(done4 == 1'b0, {req, " R2 done mid-stream"}, done4, 0);
      end
    end
    e4 = e4 + 16'(cfg & 14'h3BFF) + (ids_on(cfg, 4096) ? pack_ids(ids) : 16'h0);
    e2 = e2 + 16'(cfg & 14'h3BFF) + (ids_on(cfg, 2048) ? pack_ids(ids) : 16'h0);
    @(negedge clk);
    word_valid = 1'b0;
    word_last = 1'b0;
    check(done4 == 1'b1, {req, " R2 done pulse"}, done4, 1);
    check(sum4 == e4, {req, " sum 4K"}, sum4, e4);
    check(sum2 == e2, {req, " R13 sum 2K"}, sum2, e2);
    @(negedge clk);
    check(done4 == 1'b0, {req, " R2 done one cycle"}, done4, 0);
    check(sum4 == e4, {req, " R2 sum held"}, sum4, e4);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(done4 == 1'b0, "R1 done reset", done4, 0);
    check(sum4 == 16'h0, "R1 sum reset", sum4, 0);
  endtask

  task automatic t_blank();
    run_image(14'h3FFF, 56'h0, 4096, 0, 1'b1, 1'b0, "R3 R5 blank");
    check(sum4 == 16'h2BFF, "R3 blank 4K constant", sum4, 16'h2BFF);
    check(sum2 == 16'h33FF, "R3 blank 2K constant", sum2, 16'h33FF);
  endtask

  task automatic t_tail();
    run_image(14'h2FEF, {14'h3FF4, 14'h3FF3, 14'h3FF2, 14'h3FF1}, 4096, 5, 1'b0, 1'b0, "R6 R10 tail");
  endtask

  task automatic t_half();
    run_image(14'h1FDF, {14'h0AA9, 14'h155C, 14'h2227, 14'h3FFE}, 4096, 11, 1'b0, 1'b0, "R7 R13 half");
  endtask

  task automatic t_all();
    run_image(14'h0FCF, {14'h0004, 14'h0003, 14'h0002, 14'h0001}, 64, 3, 1'b0, 1'b0, "R8 all");
    check(sum4 == 16'(14'h0FCF & 14'h3BFF) + 16'h1234, "R10 packed 0x1234", sum4,
          16'(14'h0FCF & 14'h3BFF) + 16'h1234);
  endtask

  task automatic t_mismatch();
    run_image(14'h2FDF, {14'h0004, 14'h0003, 14'h0002, 14'h0001}, 4096, 7, 1'b0, 1'b0, "R9 mismatch");
  endtask

  task automatic t_cfg_mask();
    cfg_word = 14'h3FFF;
    id_words = 56'h0;
    pulse_start();
    @(negedge clk);
    word_valid = 1'b1;
    word_last = 1'b1;
    word_addr = 14'h1FFF;
    word_data = 14'h3FFF;
    @(negedge clk);
    word_valid = 1'b0;
    word_last = 1'b0;
    check(sum4 == 16'h3BFF, "R4 R5 cfg masked, high addr skipped", sum4, 16'h3BFF);
    check(sum2 == 16'h3BFF, "R4 cfg masked 2K", sum2, 16'h3BFF);
  endtask

  task automatic t_start_gaps();
    cfg_word = 14'h3FFF;
    @(negedge clk);
    word_valid = 1'b1;
    word_last = 1'b0;
    word_addr = 14'd5;
    word_data = 14'h1234;
    @(negedge clk);
    word_valid = 1'b0;
    run_image(14'h3FFF, 56'h0, 200, 9, 1'b0, 1'b1, "R11 R12 start gaps");
  endtask

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    word_valid = 1'b0;
    word_last = 1'b0;
    word_addr = '0;
    word_data = '0;
    cfg_word = 14'h3FFF;
    id_words = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_blank();
    t_tail();
    t_half();
    t_all();
    t_mismatch();
    t_cfg_mask();
    t_start_gaps();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests_run++;
      tests_failed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end
endmodule